// File: doc/BRIEF.md
# Coupling-Fault RAM Emulator

This block is a one-bit-wide random-access memory with a single synchronous port. It can be configured to misbehave like a memory that has a static fault between two cells. One cell is chosen as the aggressor and another as the victim. A fault class is selected, together with the aggressor and victim values that qualify it. Logic next to the storage watches every access to the two chosen cells. When the configured condition is met, it corrupts either the stored victim bit or the value returned by a read of the victim.

The block stands in for a real memory when a test algorithm or a built-in self-test controller is being evaluated. A march sequence run against it should report a mismatch for every class. This must hold with the aggressor below the victim and with the aggressor above it. With class zero, or after a rejected configuration, the block is an ordinary memory with one cycle of read latency.

Configuration is written in one cycle through `cfg_we`. Accesses in that same cycle still use the previous configuration. Writing the configuration never changes cell contents.

Top module: `cfram_top`

## Requirements
- R1: After reset every cell reads 0, `mem_rdata` is 0 and no fault is active.
- R2: With no fault active, a write stores `mem_wdata` at `mem_addr`. A read returns the stored bit on `mem_rdata` one cycle after it is issued, and `mem_rdata` holds between reads.
- R3: A configuration write whose aggressor and victim addresses are equal is refused. The fault class becomes 0 (none) and the memory behaves fault-free.
- R4: Class 1 (state): whenever the aggressor holds the aggressor value x, the victim cannot keep the victim value y. It is driven to the complement of y within the same cycle, with no access needed.
- R5: Class 2 (disturb): an access to the aggressor while it holds x sets the victim to y. The access is a read when `cfg_trig_read` is 1. It is a write of `cfg_trig_wdata` when `cfg_trig_read` is 0. Other accesses to the aggressor leave the victim alone.
- R6: Class 3 (transition): while the aggressor holds x and the victim holds y, a write of the complement of y to the victim is lost and the victim keeps y.
- R7: Class 4 (write-destructive): while the aggressor holds x and the victim holds y, a write of y to the victim leaves the complement of y in it.
- R8: Class 5 (read-destructive): while the aggressor holds x and the victim holds y, a read of the victim returns the complement of y and leaves the complement of y stored.
- R9: Class 6 (incorrect read): under the same condition, a read of the victim returns the complement of y and the stored bit stays y.
- R10: Class 7 (deceptive read): under the same condition, a read of the victim returns y and the stored bit becomes the complement of y.
- R11: Every class behaves the same whether the aggressor address is below or above the victim address.
- R12: A victim update caused by an aggressor write lands at the same clock edge as that write. A read of either cell issued in the next cycle sees both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the fault configuration this cycle |
| cfg_aggr_addr | input | AW | Aggressor cell address |
| cfg_vict_addr | input | AW | Victim cell address |
| cfg_class | input | 3 | Fault class code, 0 none through 7 deceptive read |
| cfg_aggr_state | input | 1 | Aggressor value x that qualifies the fault |
| cfg_vict_state | input | 1 | Victim value y (forced value for disturb) |
| cfg_trig_read | input | 1 | Disturb trigger: 1 read of aggressor, 0 write |
| cfg_trig_wdata | input | 1 | Disturb trigger write value when the trigger is a write |
| mem_en | input | 1 | Access request |
| mem_we | input | 1 | 1 write, 0 read |
| mem_addr | input | AW | Access address |
| mem_wdata | input | 1 | Write data |
| mem_rdata | output | 1 | Registered read data |

## Verification
An access to the aggressor and a rewrite of the victim can happen in the same cycle, and so can a state-rule re-check. The bench provokes this with every kind of aggressor access under the disturb and state classes. It then reads the victim and the aggressor in the two following cycles and compares both against a model built from the requirements, so a late or lost side update shows up. The sweep covers every class, every value of x and y, every initial pair of cell contents, every access kind on both cells, and both address orderings. A refused configuration is also tested by applying it on top of a live fault.

// File: rtl/cfram_pkg.sv
package cfram_pkg;

  typedef enum logic [2:0] {
    CF_NONE    = 3'd0,
    CF_STATE   = 3'd1,
    CF_DISTURB = 3'd2,
    CF_TRANS   = 3'd3,
    CF_WRDES   = 3'd4,
    CF_RDDES   = 3'd5,
    CF_INCRD   = 3'd6,
    CF_DECRD   = 3'd7
  } cf_class_e;

  typedef struct packed {
    cf_class_e cls;
    logic      aggr_st;
    logic      vict_st;
    logic      trig_rd;
    logic      trig_wd;
  } cf_qual_t;

endpackage

// File: rtl/cfram_cfg.sv
module cfram_cfg
  import cfram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_we,
  input  logic [AW-1:0] in_aggr,
  input  logic [AW-1:0] in_vict,
  input  cf_qual_t      in_qual,
  output logic [AW-1:0] q_aggr,
  output logic [AW-1:0] q_vict,
  output cf_qual_t      q_qual
);

  logic same_cell;
  assign same_cell = (in_aggr == in_vict);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_aggr <= '0;
      q_vict <= '0;
      q_qual <= '{cls: CF_NONE, default: 1'b0};
    end else if (in_we) begin
      q_aggr <= in_aggr;
      q_vict <= in_vict;
      q_qual <= in_qual;
      if (same_cell) q_qual.cls <= CF_NONE;
    end
  end

  // R3: equal addresses leave the memory fault-free
  a_r3_reject_same_cell: assert property (@(posedge clk) disable iff (rst)
    (in_we && (in_aggr == in_vict)) |=> (q_qual.cls == CF_NONE));

endmodule

// File: rtl/cfram_array.sv
module cfram_array #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          sd_en,
  input  logic [AW-1:0] sd_addr,
  input  logic          sd_bit,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] tap_a_addr,
  input  logic [AW-1:0] tap_v_addr,
  output logic          rd_bit,
  output logic          tap_a_bit,
  output logic          tap_v_bit
);

  localparam int DEPTH = 1 << AW;

  logic cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cells[g] <= 1'b0;
      else if (sd_en && (sd_addr == AW'(g)))
        cells[g] <= sd_bit;
      else if (wr_en && (wr_addr == AW'(g)))
        cells[g] <= wr_bit;
    end
  end

  assign rd_bit    = cells[rd_addr];
  assign tap_a_bit = cells[tap_a_addr];
  assign tap_v_bit = cells[tap_v_addr];

  // R2: a write not overridden by the side port lands at its address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(sd_en && (sd_addr == wr_addr)))
      |=> (cells[$past(wr_addr)] == $past(wr_bit)));

endmodule

// File: rtl/cfram_engine.sv
module cfram_engine
  import cfram_pkg::*;
#(
  parameter int AW = 4
) (
  input  cf_qual_t      qual,
  input  logic [AW-1:0] aggr_addr,
  input  logic [AW-1:0] vict_addr,
  input  logic          op_en,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic          op_wd,
  input  logic          aggr_bit,
  input  logic          vict_bit,
  input  logic          arr_rd,
  output logic          main_we,
  output logic          side_we,
  output logic          side_bit,
  output logic          rd_out
);

  logic active, hit_a, hit_v, a_qual, v_qual, trig;
  logic a_nxt, v_nxt, v_rd;

  always_comb begin
    active = (qual.cls != CF_NONE);
    hit_a  = op_en && (op_addr == aggr_addr);
    hit_v  = op_en && (op_addr == vict_addr);
    a_qual = (aggr_bit == qual.aggr_st);
    v_qual = (vict_bit == qual.vict_st);
    trig   = qual.trig_rd ? !op_we : (op_we && (op_wd == qual.trig_wd));
    a_nxt  = (hit_a && op_we) ? op_wd : aggr_bit;
    v_nxt  = (hit_v && op_we) ? op_wd : vict_bit;
    v_rd   = vict_bit;

    unique case (qual.cls)
      CF_DISTURB: if (hit_a && a_qual && trig) v_nxt = qual.vict_st;
      CF_TRANS:   if (hit_v && op_we && a_qual && v_qual && (op_wd != qual.vict_st))
                    v_nxt = vict_bit;
      CF_WRDES:   if (hit_v && op_we && a_qual && v_qual && (op_wd == qual.vict_st))
                    v_nxt = ~qual.vict_st;
      CF_RDDES:   if (hit_v && !op_we && a_qual && v_qual) begin
                    v_nxt = ~qual.vict_st;
                    v_rd  = ~qual.vict_st;
                  end
      CF_INCRD:   if (hit_v && !op_we && a_qual && v_qual) v_rd = ~qual.vict_st;
      CF_DECRD:   if (hit_v && !op_we && a_qual && v_qual) v_nxt = ~qual.vict_st;
      default:    ;
    endcase

    // state rule is judged on the values the cells will hold after this edge
    if ((qual.cls == CF_STATE) && (a_nxt == qual.aggr_st) && (v_nxt == qual.vict_st))
      v_nxt = ~qual.vict_st;
  end

  assign main_we  = op_en && op_we;
  assign side_we  = active;
  assign side_bit = v_nxt;
  assign rd_out   = (active && hit_v) ? v_rd : arr_rd;

endmodule

// File: rtl/cfram_top.sv
module cfram_top
  import cfram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_aggr_addr,
  input  logic [AW-1:0] cfg_vict_addr,
  input  logic [2:0]    cfg_class,
  input  logic          cfg_aggr_state,
  input  logic          cfg_vict_state,
  input  logic          cfg_trig_read,
  input  logic          cfg_trig_wdata,
  input  logic          mem_en,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_wdata,
  output logic          mem_rdata
);

  cf_qual_t      in_qual, qual;
  logic [AW-1:0] aggr_addr, vict_addr;
  logic          aggr_bit, vict_bit, arr_rd;
  logic          main_we, side_we, side_bit, rd_out;

  assign in_qual = '{cls:     cf_class_e'(cfg_class),
                     aggr_st: cfg_aggr_state,
                     vict_st: cfg_vict_state,
                     trig_rd: cfg_trig_read,
                     trig_wd: cfg_trig_wdata};

  cfram_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .in_we(cfg_we),
    .in_aggr(cfg_aggr_addr), .in_vict(cfg_vict_addr), .in_qual(in_qual),
    .q_aggr(aggr_addr), .q_vict(vict_addr), .q_qual(qual)
  );

  cfram_engine #(.AW(AW)) u_engine (
    .qual(qual), .aggr_addr(aggr_addr), .vict_addr(vict_addr),
    .op_en(mem_en), .op_we(mem_we), .op_addr(mem_addr), .op_wd(mem_wdata),
    .aggr_bit(aggr_bit), .vict_bit(vict_bit), .arr_rd(arr_rd),
    .main_we(main_we), .side_we(side_we), .side_bit(side_bit), .rd_out(rd_out)
  );

  cfram_array #(.AW(AW)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(main_we), .wr_addr(mem_addr), .wr_bit(mem_wdata),
    .sd_en(side_we), .sd_addr(vict_addr), .sd_bit(side_bit),
    .rd_addr(mem_addr), .tap_a_addr(aggr_addr), .tap_v_addr(vict_addr),
    .rd_bit(arr_rd), .tap_a_bit(aggr_bit), .tap_v_bit(vict_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)                    mem_rdata <= 1'b0;
    else if (mem_en && !mem_we) mem_rdata <= rd_out;
  end

  logic vict_cond;
  assign vict_cond = (aggr_bit == qual.aggr_st) && (vict_bit == qual.vict_st);

  // R2: fault-free read returns the array bit one cycle later
  a_r2_plain_read: assert property (@(posedge clk) disable iff (rst)
    ((qual.cls == CF_NONE) && mem_en && !mem_we) |=> (mem_rdata == $past(arr_rd)));

  // R4: with a stable state-class configuration the forbidden pair never persists
  a_r4_state_pair: assert property (@(posedge clk) disable iff (rst)
    (qual.cls == CF_STATE) |=>
      (!$stable(qual) || !$stable(aggr_addr) || !$stable(vict_addr) || !vict_cond));

  // R5 and R12: a qualifying aggressor access sets the victim at the same edge
  a_r5_disturb: assert property (@(posedge clk) disable iff (rst)
    ((qual.cls == CF_DISTURB) && mem_en && (mem_addr == aggr_addr) &&
     (aggr_bit == qual.aggr_st) &&
     (qual.trig_rd ? !mem_we : (mem_we && (mem_wdata == qual.trig_wd))))
      |=> (vict_bit == $past(qual.vict_st)));

  // R6: a blocked transition leaves the victim unchanged
  a_r6_trans_blocked: assert property (@(posedge clk) disable iff (rst)
    ((qual.cls == CF_TRANS) && mem_en && mem_we && (mem_addr == vict_addr) &&
     vict_cond && (mem_wdata != qual.vict_st)) |=> $stable(vict_bit));

  // R8: destructive read flips both output and content
  a_r8_rd_destroy: assert property (@(posedge clk) disable iff (rst)
    ((qual.cls == CF_RDDES) && mem_en && !mem_we && (mem_addr == vict_addr) && vict_cond)
      |=> ((mem_rdata == !$past(qual.vict_st)) && (vict_bit == !$past(qual.vict_st))));

  // R9: incorrect read keeps the content
  a_r9_rd_wrong: assert property (@(posedge clk) disable iff (rst)
    ((qual.cls == CF_INCRD) && mem_en && !mem_we && (mem_addr == vict_addr) && vict_cond)
      |=> ((mem_rdata == !$past(qual.vict_st)) && (vict_bit == $past(qual.vict_st))));

endmodule

// File: tb/tb_cfram_top.sv
module tb_cfram_top;

  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_aggr_addr = '0, cfg_vict_addr = '0;
  logic [2:0]    cfg_class = '0;
  logic          cfg_aggr_state = 1'b0, cfg_vict_state = 1'b0;
  logic          cfg_trig_read = 1'b0, cfg_trig_wdata = 1'b0;
  logic          mem_en = 1'b0, mem_we = 1'b0, mem_wdata = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic          mem_rdata;

  always #10 clk = ~clk;

  cfram_top #(.AW(AW)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // requirement-level model
  logic          mm [DEPTH];
  int            m_cls = 0;
  logic [AW-1:0] m_a = '0, m_v = '0;
  logic          m_x = 1'b0, m_y = 1'b0, m_trd = 1'b0, m_twd = 1'b0;

  task automatic mdl_step(input logic en, input logic we, input logic [AW-1:0] ad,
                          input logic wd, output logic rd);
    logic ca, cv, ha, hv, aq, vq, trig, an, vn, vr;
    ca = mm[m_a]; cv = mm[m_v];
    rd = mm[ad];
    if (m_cls == 0) begin
      if (en && we) mm[ad] = wd;
      return;
    end
    ha = en && (ad == m_a); hv = en && (ad == m_v);
    aq = (ca == m_x); vq = (cv == m_y);
    trig = m_trd ? !we : (we && wd == m_twd);
    an = (ha && we) ? wd : ca;
    vn = (hv && we) ? wd : cv;
    vr = cv;
    case (m_cls)
      2: if (ha && aq && trig) vn = m_y;                           // R5
      3: if (hv && we && aq && vq && wd != m_y) vn = cv;            // R6
      4: if (hv && we && aq && vq && wd == m_y) vn = !m_y;          // R7
      5: if (hv && !we && aq && vq) begin vn = !m_y; vr = !m_y; end // R8
      6: if (hv && !we && aq && vq) vr = !m_y;                      // R9
      7: if (hv && !we && aq && vq) vn = !m_y;                      // R10
      default: ;
    endcase
    if (m_cls == 1 && an == m_x && vn == m_y) vn = !m_y;            // R4
    if (en && we) mm[ad] = wd;
    mm[m_v] = vn;
    if (hv && !we) rd = vr;
  endtask

  task automatic do_cfg(input int cls, input logic [AW-1:0] a, input logic [AW-1:0] v,
                        input logic x, input logic y, input logic trd, input logic twd);
    logic dummy;
    cfg_we = 1'b1; cfg_class = 3'(cls); cfg_aggr_addr = a; cfg_vict_addr = v;
    cfg_aggr_state = x; cfg_vict_state = y; cfg_trig_read = trd; cfg_trig_wdata = twd;
    mdl_step(1'b0, 1'b0, '0, 1'b0, dummy);
    m_a = a; m_v = v; m_x = x; m_y = y; m_trd = trd; m_twd = twd;
    m_cls = (a == v) ? 0 : cls;                                     // R3
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_wr(input logic [AW-1:0] ad, input logic wd);
    logic dummy;
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = ad; mem_wdata = wd;
    mdl_step(1'b1, 1'b1, ad, wd, dummy);
    @(negedge clk);
    mem_en = 1'b0; mem_we = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] ad, input string req, input string ctx);
    logic e;
    mem_en = 1'b1; mem_we = 1'b0; mem_addr = ad;
    mdl_step(1'b1, 1'b0, ad, 1'b0, e);
    @(negedge clk);
    mem_en = 1'b0;
    n_chk++;
    if (mem_rdata !== e) begin
      n_fail++;
      $display("FAIL %s %s addr=%0d actual=%b expected=%b", req, ctx, ad, mem_rdata, e);
    end
  endtask

  function automatic string req_of(input int cls);
    case (cls)
      1: return "R4";  2: return "R5";  3: return "R6";  4: return "R7";
      5: return "R8";  6: return "R9";  7: return "R10";
      default: return "R2";
    endcase
  endfunction

  initial begin
    foreach (mm[i]) mm[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    n_chk++;
    if (mem_rdata !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 rdata after reset actual=%b expected=0", mem_rdata);
    end
    for (int i = 0; i < DEPTH; i++) do_rd(AW'(i), "R1", "reset contents");

    // R2: fault-free pattern, parity of the address, then its complement
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < DEPTH; i++) do_wr(AW'(i), (^AW'(i)) ^ p[0]);
      for (int i = 0; i < DEPTH; i++) do_rd(AW'(i), "R2", "plain pattern");
    end
    // R2: output holds between reads
    do_rd(AW'(1), "R2", "hold setup");
    do_wr(AW'(1), 1'b0);
    n_chk++;
    if (mem_rdata !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 rdata hold actual=%b expected=0", mem_rdata);
    end

    // R3: live fault replaced by a refused configuration
    do_cfg(0, 3, 12, 0, 0, 0, 0);
    do_wr(3, 1'b1); do_wr(12, 1'b1);
    do_cfg(6, 3, 12, 1, 1, 0, 0);
    do_rd(12, "R9", "before reject");
    do_cfg(6, 5, 5, 1, 1, 0, 0);
    do_rd(12, "R3", "victim after reject");
    do_wr(5, 1'b1);
    do_rd(5, "R3", "same-cell config");

    // exhaustive sweep; R11 via both orderings, R12 via reads right after aggressor ops
    for (int cls = 1; cls < 8; cls++)
      for (int ord = 0; ord < 2; ord++)
        for (int xy = 0; xy < 4; xy++)
          for (int dv = 0; dv < ((cls == 2) ? 3 : 1); dv++)
            for (int init = 0; init < 4; init++)
              for (int opi = 0; opi < 6; opi++) begin
                logic [AW-1:0] a, v, tgt;
                string ctx;
                a = (ord == 0) ? AW'(3) : AW'(12);
                v = (ord == 0) ? AW'(12) : AW'(3);
                ctx = $sformatf("cls=%0d ord=%0d x=%0d y=%0d trig=%0d init=%0d op=%0d",
                                cls, ord, xy[1], xy[0], dv, init, opi);
                do_cfg(0, a, v, 0, 0, 0, 0);
                do_wr(a, init[1]);
                do_wr(v, init[0]);
                do_cfg(cls, a, v, xy[1], xy[0], (dv == 0), (dv == 2));
                tgt = (opi < 3) ? a : v;
                if ((opi % 3) == 0) do_rd(tgt, req_of(cls), {ctx, " op-read"});
                else do_wr(tgt, ((opi % 3) == 2));
                do_rd(v, req_of(cls), {ctx, " victim"});
                do_rd(a, req_of(cls), {ctx, " aggressor"});
              end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule